// File: doc/BRIEF.md
# Restoring Shift-Subtract Divider

This block divides a double-width unsigned dividend by a single-width unsigned divisor over several clock cycles. A start pulse loads the operands. The block then runs one trial subtraction per clock. It produces a single-width quotient and a single-width remainder.

The divisor is held in a double-width register. At load time the divisor sits in the upper half of that register. The working remainder starts as the full dividend. On each step the shifted divisor is subtracted from the remainder:
- If the result is not negative, it is kept and a 1 enters the quotient from the right.
- If the result is negative, the old remainder is restored and a 0 enters the quotient.

After each step the divisor register moves one place to the right.

The loop runs `N+1` times. The result appears on two words: the remainder on the high word and the quotient on the low word. A zero divisor skips the loop and raises a flag.

The controller is a three-state machine with these states and transitions:

| State | Transition | Condition | Next state |
|-------|------------|-----------|------------|
| `ST_IDLE` | start with a non-zero divisor | | `ST_RUN` |
| `ST_IDLE` | start with a zero divisor | | `ST_FIN` |
| `ST_RUN` | stay | fewer than `N+1` steps done | `ST_RUN` |
| `ST_RUN` | finish | the step that completes `N+1` steps | `ST_FIN` |
| `ST_FIN` | always, after one cycle | | `ST_IDLE` |

Top module: `restoring_divider`

## Requirements
- R1: When the upper dividend word is below the divisor, `res_lo` equals floor(dividend / divisor) once `done` is high.
- R2: Under the same condition, `res_hi` equals dividend mod divisor, which is always below the divisor.
- R3: A start taken in idle with a non-zero divisor sets `busy` for exactly `N+1` cycles. `done` is high in the cycle that follows the last of those cycles.
- R4: `done` is high for one cycle only, and `busy` and `done` are never high together.
- R5: A start with a zero divisor runs no steps. In the next cycle `done` and `div_zero` are high, `res_lo` is all ones, and `res_hi` equals the lower dividend word.
- R6: `res_hi`, `res_lo` and `div_zero` keep their values from `done` until the next accepted start.
- R7: `start` is ignored while `busy` or `done` is high. The operands presented then do not affect the result that is being produced.
- R8: After reset the block is idle with `busy`, `done`, `div_zero`, `res_hi` and `res_lo` all zero.
- R9: An accepted start with a non-zero divisor clears `div_zero`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; taken only when idle |
| dividend | input | 2N | Unsigned dividend |
| divisor | input | N | Unsigned divisor |
| busy | output | 1 | Subtract-shift loop running |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Last accepted divisor was zero |
| res_hi | output | N | Remainder |
| res_lo | output | N | Quotient |

## Verification
The assertions and the result checks assume that every non-zero division has an upper dividend word below the divisor. Without that, the quotient needs more than `N` bits and the remainder is not fully reduced. The random stimulus draws the upper word modulo the divisor. The directed cases sit exactly at that limit, using an upper word of divisor minus one. The assertions also assume that `start` is only meaningful in idle. The bench deliberately raises it mid-run to show it is ignored.

// File: rtl/div_pkg.sv
package div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_e;
endpackage

// File: rtl/div_step.sv
// One restoring trial: subtract with an extra borrow bit, keep or restore.
module div_step #(
    parameter int W = 64
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] dvs_in,
    output logic [W-1:0] rem_out,
    output logic         q_bit
);
    logic [W:0] diff;

    always_comb begin
        diff    = {1'b0, rem_in} - {1'b0, dvs_in};
        q_bit   = ~diff[W];
        // a borrow means the trial went negative: the old remainder stands
        rem_out = diff[W] ? rem_in : diff[W-1:0];
    end
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
    import div_pkg::*;
#(
    parameter int N = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dvs_zero,
    output logic busy,
    output logic done,
    output logic load,
    output logic zload,
    output logic step
);
    localparam int CW = $clog2(N + 2);
    localparam logic [CW-1:0] LAST = CW'(N);

    div_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    // state register and step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load)
                cnt_q <= '0;
            else if (step)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = dvs_zero ? ST_FIN : ST_RUN;
            ST_RUN:  if (cnt_q == LAST) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy  = (state_q == ST_RUN);
        done  = (state_q == ST_FIN);
        step  = (state_q == ST_RUN);
        load  = (state_q == ST_IDLE) && start && !dvs_zero;
        zload = (state_q == ST_IDLE) && start && dvs_zero;
    end
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
    parameter int N = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2*N-1:0] dividend,
    input  logic [N-1:0]   divisor,
    output logic           busy,
    output logic           done,
    output logic           div_zero,
    output logic [N-1:0]   res_hi,
    output logic [N-1:0]   res_lo
);
    localparam int W = 2 * N;

    logic [W-1:0] rem_q, dvs_q, rem_nx;
    logic [N-1:0] quo_q;
    logic         dz_q, q_bit;
    logic         load, zload, step;

    div_ctrl #(.N(N)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dvs_zero (divisor == '0),
        .busy     (busy),
        .done     (done),
        .load     (load),
        .zload    (zload),
        .step     (step)
    );

    div_step #(.W(W)) u_step (
        .rem_in  (rem_q),
        .dvs_in  (dvs_q),
        .rem_out (rem_nx),
        .q_bit   (q_bit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            dvs_q <= '0;
            quo_q <= '0;
            dz_q  <= 1'b0;
        end else if (load) begin
            rem_q <= dividend;
            dvs_q <= {divisor, {N{1'b0}}};
            quo_q <= '0;
            dz_q  <= 1'b0;
        end else if (zload) begin
            rem_q <= dividend;
            dvs_q <= '0;
            quo_q <= '1;
            dz_q  <= 1'b1;
        end else if (step) begin
            rem_q <= rem_nx;
            quo_q <= {quo_q[N-2:0], q_bit};
            dvs_q <= dvs_q >> 1;
        end
    end

    assign res_hi   = rem_q[N-1:0];
    assign res_lo   = quo_q;
    assign div_zero = dz_q;
endmodule

// File: rtl/restoring_divider_chk.sv
module restoring_divider_chk #(
    parameter int N = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [N-1:0]   divisor,
    input logic           busy,
    input logic           done,
    input logic           div_zero,
    input logic [N-1:0]   res_hi,
    input logic [N-1:0]   res_lo
);
    logic [N-1:0] cap_q;
    logic         taken;

    assign taken = start && !busy && !done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cap_q <= '0;
        else if (taken)
            cap_q <= divisor;
    end

    a_r4_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && divisor != '0) |=> busy);

    a_r5_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && divisor == '0) |=> (done && div_zero && res_lo == '1));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(res_hi) && $stable(res_lo) && $stable(div_zero)));

    a_r2_rem_below: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero) |-> (res_hi < cap_q));
endmodule

bind restoring_divider restoring_divider_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .divisor  (divisor),
    .busy     (busy),
    .done     (done),
    .div_zero (div_zero),
    .res_hi   (res_hi),
    .res_lo   (res_lo)
);

// File: tb/tb_restoring_divider.sv
module tb_restoring_divider;
    localparam int N = 32;
    localparam int CLK_PERIOD = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [2*N-1:0] dividend = '0;
    logic [N-1:0]   divisor = '0;
    logic           busy, done, div_zero;
    logic [N-1:0]   res_hi, res_lo;

    int n_run = 0;
    int n_fail = 0;

    restoring_divider #(.N(N)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .busy(busy), .done(done), .div_zero(div_zero),
        .res_hi(res_hi), .res_lo(res_lo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [N-1:0] exp_quo(logic [2*N-1:0] a, logic [N-1:0] b);
        logic [2*N-1:0] q;
        q = a / {{N{1'b0}}, b};
        return q[N-1:0];
    endfunction

    function automatic logic [N-1:0] exp_rem(logic [2*N-1:0] a, logic [N-1:0] b);
        logic [2*N-1:0] r;
        r = a % {{N{1'b0}}, b};
        return r[N-1:0];
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [2*N-1:0] act, input logic [2*N-1:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Start one division; optionally poke start with other operands mid-run.
    task automatic divide(input logic [2*N-1:0] a, input logic [N-1:0] b,
                          input logic poke);
        int cyc;
        int busy_cyc;
        logic [N-1:0] q_e, r_e;
        @(negedge clk);
        dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0; busy_cyc = 0;
        while (!done && cyc < 200) begin
            if (busy) busy_cyc++;
            if (poke && cyc == 3) begin
                dividend = ~a; divisor = b ^ 32'h5; start = 1'b1;   // R7
            end
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        if (b == '0) begin
            check(cyc == 0, "R5 latency", cyc, 0);
            check(div_zero == 1'b1, "R5 flag", div_zero, 1);
            check(res_lo == '1, "R5 quotient", res_lo, {N{1'b1}});
            check(res_hi == a[N-1:0], "R5 high word", res_hi, a[N-1:0]);
        end else begin
            q_e = exp_quo(a, b);
            r_e = exp_rem(a, b);
            check(cyc == N + 1, "R3 latency", cyc, N + 1);
            check(busy_cyc == N + 1, "R3 busy span", busy_cyc, N + 1);
            check(res_lo == q_e, poke ? "R7 quotient" : "R1 quotient", res_lo, q_e);
            check(res_hi == r_e, poke ? "R7 remainder" : "R2 remainder", res_hi, r_e);
            check(div_zero == 1'b0, "R9 flag cleared", div_zero, 0);
        end
        @(negedge clk);
        check(done == 1'b0, "R4 one-cycle done", done, 0);
        // R6: outputs unchanged in idle while operands move
        dividend = ~dividend; divisor = ~divisor;
        @(negedge clk);
        @(negedge clk);
        if (b == '0)
            check(res_lo == '1 && res_hi == a[N-1:0], "R6 hold", res_lo, {N{1'b1}});
        else
            check(res_lo == exp_quo(a, b) && res_hi == exp_rem(a, b), "R6 hold",
                  res_lo, exp_quo(a, b));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [N-1:0] b, hi, lo;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && div_zero == 0, "R8 reset flags",
              {busy, done, div_zero}, 0);
        check(res_hi == 0 && res_lo == 0, "R8 reset results", {res_hi, res_lo}, 0);
        rst_n = 1'b1;

        // directed corners
        divide(64'd100, 32'd7, 1'b0);
        divide(64'd0, 32'd9, 1'b0);
        divide(64'd5, 32'd9, 1'b0);                              // dividend below divisor
        divide(64'd9, 32'd9, 1'b0);                              // equal
        divide({32'd0, 32'hFFFF_FFFF}, 32'd1, 1'b0);             // divide by one
        divide({32'hFFFF_FFFE, 32'hFFFF_FFFF}, 32'hFFFF_FFFF, 1'b0); // largest quotient
        divide({32'h0000_0003, 32'h1234_5678}, 32'd4, 1'b0);     // upper word = divisor-1
        divide(64'h1234_5678_9ABC_DEF0, 32'd0, 1'b0);            // zero divisor
        divide(64'd1000, 32'd3, 1'b0);                           // flag cleared again
        divide({32'h0000_0010, 32'hCAFE_F00D}, 32'h0000_1234, 1'b1); // start ignored

        // constrained random
        for (int i = 0; i < 40; i++) begin
            b = $urandom;
            if (b == '0) b = 32'd1;
            hi = $urandom % b;
            lo = $urandom;
            divide({hi, lo}, b, (i % 8) == 5);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule